// File: doc/BRIEF.md
# Packed Single-Precision Compare Unit

This unit compares two 128-bit operands. Each operand holds four IEEE-754 single-precision lanes, with lane 0 in bits 31:0. A mode select picks one of three jobs. Packed mode turns each lane pair into a 32-bit mask that is all ones or all zeros, under one of eight predicates. Scalar mode does the same for lane 0 only and copies the rest of the first operand through. Flag mode compares lane 0 of each operand and reports the relation on three flag bits. It also raises an invalid-operation flag, whose NaN sensitivity is set by a signalling/quiet select.

All outputs are registered, so each result appears one clock after its inputs are presented. The unit has no rounding, denormal flushing or exception masking. Ordering of non-NaN values comes from a sign-magnitude comparison of the raw bit patterns.

Top module: `fcmp_unit`

## Requirements
- R1: A synchronous active-high reset clears every output to zero. Outside reset, each output reflects the inputs sampled on the previous rising clock edge.
- R2: In packed mode (mode 00, and the reserved mode 11, which acts the same), every 32-bit lane of the result is all ones when its predicate holds and all zeros otherwise. The predicate codes are 0 EQ, 1 LT, 2 LE, 3 UNORD, 4 NEQ, 5 NLT, 6 NLE, 7 ORD, each applied as "a pred b".
- R3: A value is a NaN when its exponent bits 30:23 are all ones and its fraction bits 22:0 are non-zero. Any lane pair that contains a NaN is unordered. For such a pair, EQ, LT, LE and ORD are false, and UNORD, NEQ, NLT and NLE are true.
- R4: +0 (0x00000000) and -0 (0x80000000) compare equal and neither is less than the other.
- R5: Non-NaN values are ordered by sign and magnitude. A negative value is below every positive value. Among negative values, the one with the larger magnitude is the lesser. Infinities take part like any other value.
- R6: In scalar mode (mode 01), result bits 31:0 hold the lane-0 mask under the predicate, and bits 127:32 equal bits 127:32 of operand a.
- R7: In flag mode (mode 10), {zf,pf,cf} is 111 for unordered, 000 when a > b, 001 when a < b and 100 when a = b, on the lane-0 values. The 128-bit result is zero in this mode.
- R8: In flag mode with signal_nan = 1, inv is set when either lane-0 operand is any NaN, quiet or signalling.
- R9: In flag mode with signal_nan = 0, inv is set only when either lane-0 operand is a signalling NaN, meaning fraction bit 22 is clear. A quiet NaN, with bit 22 set, leaves inv clear.
- R10: Outside flag mode, zf, pf, cf and inv are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 128 | First operand, four single-precision lanes |
| op_b | input | 128 | Second operand, four single-precision lanes |
| pred | input | 3 | Predicate code for packed and scalar modes |
| mode | input | 2 | 00 packed, 01 scalar, 10 flags, 11 packed |
| signal_nan | input | 1 | 1 selects the signalling variant in flag mode |
| res | output | 128 | Registered mask or pass-through result |
| zf | output | 1 | Registered zero/equal flag |
| pf | output | 1 | Registered unordered flag |
| cf | output | 1 | Registered less-than flag |
| inv | output | 1 | Registered invalid-operation flag |

## Verification
The bench goes after signed zeros. A unit that compares raw bits would call +0 and -0 unequal and would report -0 as less than +0. It also mixes negative operands: a unit that treats the patterns as unsigned integers would invert the order of negative values and place every negative value above every positive one. Quiet and signalling NaNs go through both flag variants and all eight predicates. A unit that handles the negated predicates wrongly would return false for NEQ, NLT or NLE on NaNs, and one that mixes up the variants would raise or drop inv on a quiet NaN. Scalar mode is checked for corruption of the upper lanes, and flag mode for stale flags left in the other modes.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  typedef enum logic [1:0] {
    MODE_PACKED = 2'b00,
    MODE_SCALAR = 2'b01,
    MODE_FLAGS  = 2'b10,
    MODE_RSVD   = 2'b11
  } cmp_mode_e;

  typedef enum logic [2:0] {
    PR_EQ    = 3'd0,
    PR_LT    = 3'd1,
    PR_LE    = 3'd2,
    PR_UNORD = 3'd3,
    PR_NEQ   = 3'd4,
    PR_NLT   = 3'd5,
    PR_NLE   = 3'd6,
    PR_ORD   = 3'd7
  } cmp_pred_e;

  // Relation of one lane pair; eq and lt are only set for ordered pairs.
  typedef struct packed {
    logic unord;
    logic lt;
    logic eq;
  } lane_rel_t;

  // NaN classification of one lane pair.
  typedef struct packed {
    logic a_nan;
    logic a_snan;
    logic b_nan;
    logic b_snan;
  } lane_cls_t;

endpackage

// File: rtl/fcmp_lane.sv
module fcmp_lane
  import fcmp_pkg::*;
#(
  parameter int EW = 8,
  parameter int MW = 23,
  localparam int FW = 1 + EW + MW
) (
  input  logic [FW-1:0] a,
  input  logic [FW-1:0] b,
  output lane_rel_t     rel,
  output lane_cls_t     cls
);

  logic [FW-2:0] mag_a, mag_b;
  logic          sgn_a, sgn_b;
  logic          nan_a, nan_b;
  logic          both_zero, eq_raw, lt_raw;

  assign mag_a = a[FW-2:0];
  assign mag_b = b[FW-2:0];
  assign sgn_a = a[FW-1];
  assign sgn_b = b[FW-1];

  assign nan_a = (a[FW-2:MW] == '1) && (a[MW-1:0] != '0);
  assign nan_b = (b[FW-2:MW] == '1) && (b[MW-1:0] != '0);

  assign both_zero = (mag_a == '0) && (mag_b == '0);
  assign eq_raw    = both_zero || (a == b);

  always_comb begin
    if (both_zero)           lt_raw = 1'b0;
    else if (sgn_a != sgn_b) lt_raw = sgn_a;
    else if (!sgn_a)         lt_raw = (mag_a < mag_b);
    else                     lt_raw = (mag_a > mag_b);
  end

  assign rel.unord = nan_a | nan_b;
  assign rel.eq    = eq_raw & ~rel.unord;
  assign rel.lt    = lt_raw & ~rel.unord;

  assign cls.a_nan  = nan_a;
  assign cls.a_snan = nan_a & ~a[MW-1];
  assign cls.b_nan  = nan_b;
  assign cls.b_snan = nan_b & ~b[MW-1];

  // R5: the order and equality paths never both claim a pair
  always_comb begin
    a_rel_exclusive_r5 : assert (!(rel.lt && rel.eq) || $isunknown({a, b}));
  end

endmodule

// File: rtl/fcmp_pred.sv
module fcmp_pred
  import fcmp_pkg::*;
(
  input  lane_rel_t  rel,
  input  logic [2:0] pred,
  output logic       hit
);

  logic le;
  assign le = rel.lt | rel.eq;

  always_comb begin
    unique case (cmp_pred_e'(pred))
      PR_EQ:    hit = rel.eq;
      PR_LT:    hit = rel.lt;
      PR_LE:    hit = le;
      PR_UNORD: hit = rel.unord;
      PR_NEQ:   hit = ~rel.eq;
      PR_NLT:   hit = ~rel.lt;
      PR_NLE:   hit = ~le;
      PR_ORD:   hit = ~rel.unord;
      default:  hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int EW    = 8,
  parameter int MW    = 23,
  localparam int FW   = 1 + EW + MW,
  localparam int DW   = LANES * FW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [2:0]    pred,
  input  logic [1:0]    mode,
  input  logic          signal_nan,
  output logic [DW-1:0] res,
  output logic          zf,
  output logic          pf,
  output logic          cf,
  output logic          inv
);

  lane_rel_t        rel  [LANES];
  lane_cls_t        cls  [LANES];
  logic [LANES-1:0] hit;
  logic [DW-1:0]    packed_mask;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    fcmp_lane #(.EW(EW), .MW(MW)) u_lane (
      .a   (op_a[i*FW +: FW]),
      .b   (op_b[i*FW +: FW]),
      .rel (rel[i]),
      .cls (cls[i])
    );
    fcmp_pred u_pred (
      .rel  (rel[i]),
      .pred (pred),
      .hit  (hit[i])
    );
    assign packed_mask[i*FW +: FW] = {FW{hit[i]}};
  end

  logic [DW-1:0] res_d;
  logic [2:0]    flg_d;
  logic          inv_d;
  logic          lo_any_nan, lo_any_snan;

  assign lo_any_nan  = cls[0].a_nan  | cls[0].b_nan;
  assign lo_any_snan = cls[0].a_snan | cls[0].b_snan;

  always_comb begin
    res_d = packed_mask;
    flg_d = 3'b000;
    inv_d = 1'b0;
    unique case (cmp_mode_e'(mode))
      MODE_SCALAR: res_d = {op_a[DW-1:FW], packed_mask[FW-1:0]};
      MODE_FLAGS: begin
        res_d = '0;
        if (rel[0].unord)   flg_d = 3'b111;
        else if (rel[0].eq) flg_d = 3'b100;
        else if (rel[0].lt) flg_d = 3'b001;
        else                flg_d = 3'b000;
        inv_d = signal_nan ? lo_any_nan : lo_any_snan;
      end
      default: res_d = packed_mask;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res          <= '0;
      {zf, pf, cf} <= 3'b000;
      inv          <= 1'b0;
    end else begin
      res          <= res_d;
      {zf, pf, cf} <= flg_d;
      inv          <= inv_d;
    end
  end

  // ---------------- assertions ----------------
  p_reset_clear_r1 : assert property (@(posedge clk)
    rst |=> (res == '0 && {zf, pf, cf} == 3'b000 && !inv));

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    p_mask_uniform_r2 : assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_PACKED || mode == MODE_RSVD) |=>
        (res[i*FW +: FW] == '0 || res[i*FW +: FW] == '1));
  end

  p_nan_unordered_r3 : assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FLAGS && lo_any_nan) |=> ({zf, pf, cf} == 3'b111));

  p_signed_zero_eq_r4 : assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_PACKED && pred == PR_EQ &&
     op_a[FW-2:0] == '0 && op_b[FW-2:0] == '0) |=> (res[FW-1:0] == '1));

  p_scalar_upper_r6 : assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SCALAR) |=> (res[DW-1:FW] == $past(op_a[DW-1:FW])));

  p_flags_legal_r7 : assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FLAGS) |=> (res == '0 &&
      ({zf, pf, cf} == 3'b111 || {zf, pf, cf} == 3'b000 ||
       {zf, pf, cf} == 3'b001 || {zf, pf, cf} == 3'b100)));

  p_sig_inv_r8 : assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FLAGS && signal_nan && lo_any_nan) |=> inv);

  p_quiet_inv_r9 : assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FLAGS && !signal_nan && !lo_any_snan) |=> !inv);

  p_idle_flags_r10 : assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_FLAGS) |=> ({zf, pf, cf} == 3'b000 && !inv));

endmodule

// File: tb/sim_fcmp_unit.sv
module sim_fcmp_unit;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] op_a = '0, op_b = '0;
  logic [2:0]   pred = '0;
  logic [1:0]   mode = '0;
  logic         signal_nan = 1'b0;
  logic [127:0] res;
  logic         zf, pf, cf, inv;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fcmp_unit u0 (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .pred(pred),
    .mode(mode), .signal_nan(signal_nan),
    .res(res), .zf(zf), .pf(pf), .cf(cf), .inv(inv)
  );

  function automatic bit is_nan(input logic [31:0] x);
    return (x[30:23] == 8'hff) && (x[22:0] != 0);
  endfunction

  // Monotonic unsigned key: larger key means larger value.
  function automatic logic [31:0] okey(input logic [31:0] x);
    if (x[30:0] == 0) return 32'h8000_0000;
    if (x[31])        return ~x;
    return x | 32'h8000_0000;
  endfunction

  // 0 eq, 1 less, 2 greater, 3 unordered
  function automatic int relate(input logic [31:0] a, input logic [31:0] b);
    if (is_nan(a) || is_nan(b)) return 3;
    if (okey(a) == okey(b))     return 0;
    if (okey(a) <  okey(b))     return 1;
    return 2;
  endfunction

  function automatic bit holds(input int r, input logic [2:0] p);
    case (p)
      3'd0: return r == 0;
      3'd1: return r == 1;
      3'd2: return r == 0 || r == 1;
      3'd3: return r == 3;
      3'd4: return r != 0;
      3'd5: return r != 1;
      3'd6: return !(r == 0 || r == 1);
      default: return r != 3;
    endcase
  endfunction

  function automatic logic [131:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [2:0] p, input logic [1:0] m,
                                         input logic s);
    logic [127:0] r = '0;
    logic [2:0]   f = 3'b000;
    logic         iv = 1'b0;
    int           rl;
    for (int i = 0; i < 4; i++)
      r[i*32 +: 32] = holds(relate(a[i*32 +: 32], b[i*32 +: 32]), p) ? 32'hffff_ffff : 32'h0;
    if (m == 2'b01) r[127:32] = a[127:32];
    if (m == 2'b10) begin
      r  = '0;
      rl = relate(a[31:0], b[31:0]);
      f  = (rl == 3) ? 3'b111 : (rl == 0) ? 3'b100 : (rl == 1) ? 3'b001 : 3'b000;
      if (s) iv = is_nan(a[31:0]) || is_nan(b[31:0]);
      else   iv = (is_nan(a[31:0]) && !a[22]) || (is_nan(b[31:0]) && !b[22]);
    end
    return {r, f, iv};
  endfunction

  task automatic apply(input logic [127:0] a, input logic [127:0] b, input logic [2:0] p,
                       input logic [1:0] m, input logic s, input string tag);
    logic [131:0] exp_v;
    @(negedge clk);
    op_a = a; op_b = b; pred = p; mode = m; signal_nan = s;
    exp_v = model(a, b, p, m, s);
    @(negedge clk);
    n_chk++;
    if ({res, zf, pf, cf, inv} !== exp_v) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, {res, zf, pf, cf, inv}, exp_v);
    end
  endtask

  function automatic logic [31:0] pick(input logic [3:0] sel, input logic [31:0] rnd);
    case (sel)
      4'd0: return 32'h0000_0000;
      4'd1: return 32'h8000_0000;
      4'd2: return 32'h7f80_0000;
      4'd3: return 32'hff80_0000;
      4'd4: return {rnd[31], 8'hff, 1'b1, rnd[21:0]};
      4'd5: return {rnd[31], 8'hff, 1'b0, rnd[21:0] | 22'd1};
      4'd6: return {rnd[31], 8'h00, rnd[22:0]};
      4'd7: return {rnd[31], 8'h3f, rnd[22:0]};
      default: return rnd;
    endcase
  endfunction

  localparam logic [31:0] QN = 32'h7fc0_0000, SN = 32'h7f80_0001;
  localparam logic [31:0] P1 = 32'h3f80_0000, N1 = 32'hbf80_0000, N2 = 32'hc000_0000;

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    n_chk++;
    if ({res, zf, pf, cf, inv} !== '0) begin
      n_bad++;
      $display("FAIL R1: reset state got %h expected 0", {res, zf, pf, cf, inv});
    end
    rst = 1'b0;

    // R2: all predicates on a mixed packed vector
    for (int p = 0; p < 8; p++)
      apply({P1, N1, QN, 32'h0}, {N1, P1, P1, 32'h8000_0000}, 3'(p), 2'b00, 1'b0, "R2");
    apply({P1, N1, P1, P1}, {P1, N1, P1, P1}, 3'd0, 2'b11, 1'b0, "R2");
    // R3: NaN in each predicate, both NaN kinds
    for (int p = 0; p < 8; p++)
      apply({QN, SN, P1, QN}, {P1, P1, SN, QN}, 3'(p), 2'b00, 1'b0, "R3");
    // R4: signed zeros
    apply({96'h0, 32'h8000_0000}, {96'h0, 32'h0}, 3'd0, 2'b00, 1'b0, "R4");
    apply({96'h0, 32'h8000_0000}, {96'h0, 32'h0}, 3'd1, 2'b00, 1'b0, "R4");
    apply({96'h0, 32'h8000_0000}, {96'h0, 32'h0}, 3'd0, 2'b10, 1'b1, "R4");
    // R5: sign-magnitude ordering, infinities
    apply({N2, N1, 32'hff80_0000, N1}, {N1, N2, N2, P1}, 3'd1, 2'b00, 1'b0, "R5");
    apply({96'h0, N2}, {96'h0, N1}, 3'd0, 2'b10, 1'b0, "R5");
    apply({96'h0, 32'h7f80_0000}, {96'h0, P1}, 3'd0, 2'b10, 1'b0, "R5");
    // R6: scalar mode
    apply({32'hdead_beef, 32'h1234_5678, SN, P1}, {N1, N1, N1, N1}, 3'd6, 2'b01, 1'b0, "R6");
    // R7: flag relations
    apply({96'h0, P1}, {96'h0, P1}, 3'd0, 2'b10, 1'b0, "R7");
    apply({96'h0, N1}, {96'h0, P1}, 3'd0, 2'b10, 1'b0, "R7");
    // R8, R9: NaN exception variants
    apply({96'h0, QN}, {96'h0, P1}, 3'd0, 2'b10, 1'b1, "R8");
    apply({96'h0, P1}, {96'h0, SN}, 3'd0, 2'b10, 1'b1, "R8");
    apply({96'h0, QN}, {96'h0, P1}, 3'd0, 2'b10, 1'b0, "R9");
    apply({96'h0, P1}, {96'h0, SN}, 3'd0, 2'b10, 1'b0, "R9");
    // R10: flags cleared when leaving flag mode
    apply({96'h0, SN}, {96'h0, QN}, 3'd3, 2'b00, 1'b1, "R10");

    for (int k = 0; k < 1500; k++) begin
      logic [127:0] a, b;
      logic [1:0]   m;
      for (int i = 0; i < 4; i++) begin
        a[i*32 +: 32] = pick(4'($urandom_range(0, 11)), $urandom);
        b[i*32 +: 32] = ($urandom_range(0, 5) == 0) ? a[i*32 +: 32]
                        : pick(4'($urandom_range(0, 11)), $urandom);
      end
      m = 2'($urandom_range(0, 3));
      apply(a, b, 3'($urandom_range(0, 7)), m, 1'($urandom_range(0, 1)),
            (m == 2'b01) ? "R6" : (m == 2'b10) ? "R7" : "R2");
    end

    rst = 1'b1;
    @(negedge clk);
    n_chk++;
    if ({res, zf, pf, cf, inv} !== '0) begin
      n_bad++;
      $display("FAIL R1: mid-run reset got %h expected 0", {res, zf, pf, cf, inv});
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule